// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational unit sits between a 32-bit processor core and a data memory whose entries are whole words. For a store it turns the effective byte address, a width code and the register operand into a word index, a write word with the operand copied into every lane it could occupy, and a per-lane write strobe, so only the addressed bytes of the memory word change. For a load it takes the word the memory returned, picks the addressed byte or halfword using the low address bits, and widens it to 32 bits with sign or zero fill.

The unit also checks alignment and the writable address window. A halfword at an odd address or a word at any non-multiple-of-four address raises a flag. Such an access never writes, and its load result is forced to zero, so behaviour is defined even though it is not supported. A write outside the window also leaves the strobe at zero. The width code uses the standard base-integer load/store function field: 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword. Any other code is illegal.

Top module: `mem_align_unit`

## Requirements
- R1: `mem_word_addr` always equals `acc_addr` shifted right by two, so `acc_addr[1:0]` selects the lane inside the word.
- R2: On a legal store, `mem_wdata` carries the low byte of `wr_data` in all four lanes for a byte code (000/100), the low halfword in both halves for a halfword code (001/101), and `wr_data` unchanged for the word code (010).
- R3: An enabled byte store drives `mem_wmask` to 4'b0001 shifted left by `acc_addr[1:0]`; lanes are little-endian, with lane 0 at bits [7:0].
- R4: An enabled halfword store drives `mem_wmask` to 4'b0011 at offset 0 and 4'b1100 at offset 2. An enabled word store drives 4'b1111.
- R5: `mem_wmask` is 4'b0000 whenever `req_valid` or `req_write` is low.
- R6: `mem_wmask` is 4'b0000 unless `acc_addr[31:30]` is 2'b00 and `acc_addr[28]` is 1. Bit 29 is not examined.
- R7: `misaligned` is high when `req_valid` is high and the access is a halfword with `acc_addr[0]`=1 or a word with `acc_addr[1:0]`≠0. In that case `mem_wmask` is 4'b0000.
- R8: A signed byte load (000) returns byte lane `acc_addr[1:0]` of `rd_word`, sign-extended from its bit 7.
- R9: Unsigned loads (100 byte, 101 halfword) return the selected lane with zeros in all upper bits.
- R10: A signed halfword load (001) returns `rd_word[15:0]` at offset 0 or `rd_word[31:16]` at offset 2, sign-extended from bit 15.
- R11: A word load (010) at offset 0 returns `rd_word` unchanged.
- R12: `ld_data` is zero when the width code is illegal (011, 110, 111) or the access is misaligned in the sense of R7, whatever the value of `req_valid`. An illegal code never writes and never raises `misaligned`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | High for a store, low for a load |
| acc_addr | input | 32 | Effective byte address |
| acc_size | input | 3 | Width and signedness code |
| wr_data | input | 32 | Register operand to be stored |
| rd_word | input | 32 | Word returned by the data memory |
| mem_word_addr | output | 30 | Word index presented to the memory |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_wmask | output | 4 | Per-lane write strobe, bit i enables bits [8i+7:8i] |
| ld_data | output | 32 | Extracted and extended load result |
| misaligned | output | 1 | Unsupported alignment for the requested width |

## Verification
The unit holds no state, so any fault in lane selection, width decoding or window matching shows at the ports in the same cycle as the offending input. A strobe on the wrong lane or with the wrong lane count appears on `mem_wmask`. A mis-picked or mis-extended lane appears in the upper or lower bits of `ld_data`. A stale alignment or window decision appears as a nonzero strobe together with `misaligned` or an out-of-window address. Random addresses that cover all four offsets and many upper nibbles, mixed with the known byte patterns, reach every lane and every width code.

// File: rtl/mau_pkg.sv
// Shared width-code constants and the decoded form used by all sub-blocks.
// Assumes the base-integer load/store function-field encoding.
package mau_pkg;

    localparam logic [2:0] SZ_BYTE   = 3'b000;
    localparam logic [2:0] SZ_HALF   = 3'b001;
    localparam logic [2:0] SZ_WORD   = 3'b010;
    localparam logic [2:0] SZ_BYTE_U = 3'b100;
    localparam logic [2:0] SZ_HALF_U = 3'b101;

    typedef struct packed {
        logic legal;
        logic is_byte;
        logic is_half;
        logic is_word;
        logic zext;
    } size_dec_t;

    // Turns a raw width code into one-hot width flags plus signedness.
    function automatic size_dec_t decode_size(input logic [2:0] code);
        size_dec_t d;
        d = '0;
        case (code)
            SZ_BYTE:   begin d.legal = 1'b1; d.is_byte = 1'b1; end
            SZ_HALF:   begin d.legal = 1'b1; d.is_half = 1'b1; end
            SZ_WORD:   begin d.legal = 1'b1; d.is_word = 1'b1; end
            SZ_BYTE_U: begin d.legal = 1'b1; d.is_byte = 1'b1; d.zext = 1'b1; end
            SZ_HALF_U: begin d.legal = 1'b1; d.is_half = 1'b1; d.zext = 1'b1; end
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mau_access_check.sv
// Decodes the width code and judges alignment and the writable window.
// Assumes lanes are bytes and the offset field is the low OFF_W address bits.
module mau_access_check
    import mau_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                OFF_W        = 2,
    parameter logic [ADDR_W-1:0] REGION_VALUE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] REGION_CARE  = 32'hD000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size_code,
    output size_dec_t         dec,
    output logic              misalign_cond,
    output logic              region_hit
);

    // Width decode, alignment rule and window compare.
    always_comb begin
        dec           = decode_size(size_code);
        misalign_cond = (dec.is_half & addr[0]) |
                        (dec.is_word & (|addr[OFF_W-1:0]));
        region_hit    = (((addr ^ REGION_VALUE) & REGION_CARE) == '0);
    end

    // A legal code selects exactly one width; an illegal code selects none.
    always_comb begin
        a_r12_one_width: assert (dec.legal ? $onehot({dec.is_byte, dec.is_half, dec.is_word})
                                           : !(dec.is_byte | dec.is_half | dec.is_word))
            else $error("width decode not one-hot");
    end

endmodule

// File: rtl/mau_store_pack.sv
// Builds the replicated write word and the per-lane strobe for a store.
// Assumes enable already folds in request, window, legality and alignment.
module mau_store_pack
    import mau_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  size_dec_t         dec,
    input  logic [OFF_W-1:0]  off,
    input  logic              enable,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  wmask
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Chooses which operand byte lands in lane i.
        always_comb begin
            if (dec.is_byte)
                wdata[8*i +: 8] = wr_data[7:0];
            else if (dec.is_half)
                wdata[8*i +: 8] = wr_data[8*(i%2) +: 8];
            else
                wdata[8*i +: 8] = wr_data[8*i +: 8];
        end

        // Decides whether lane i is written.
        always_comb begin
            wmask[i] = enable & (dec.is_word |
                       (dec.is_half & (off[OFF_W-1:1] == (OFF_W-1)'(i / 2))) |
                       (dec.is_byte & (off == OFF_W'(i))));
        end
    end

    // Enabled stores touch exactly one, two or all lanes.
    always_comb begin
        if (enable && dec.is_byte)
            a_r3_byte_onehot: assert ($onehot(wmask)) else $error("byte strobe not one lane");
        if (enable && dec.is_half)
            a_r4_half_two: assert ($countones(wmask) == 2) else $error("half strobe not two lanes");
    end

endmodule

// File: rtl/mau_load_extract.sv
// Picks the addressed lane of a returned word and widens it.
// Assumes kill is raised for misaligned accesses; illegal codes yield zero.
module mau_load_extract
    import mau_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  size_dec_t         dec,
    input  logic [OFF_W-1:0]  off,
    input  logic              kill,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ld_data
);

    localparam int HALVES = LANES / 2;

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [HALVES];
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign byte_lane[i] = rd_word[8*i +: 8];
    end
    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign half_lane[j] = rd_word[16*j +: 16];
    end

    // Lane selection by offset.
    always_comb begin
        sel_byte = byte_lane[off];
        sel_half = half_lane[off[OFF_W-1:1]];
    end

    // Width-dependent widening with sign or zero fill.
    always_comb begin
        if (kill || !dec.legal)
            ld_data = '0;
        else if (dec.is_byte)
            ld_data = {{(DATA_W-8){sel_byte[7] & ~dec.zext}}, sel_byte};
        else if (dec.is_half)
            ld_data = {{(DATA_W-16){sel_half[15] & ~dec.zext}}, sel_half};
        else
            ld_data = rd_word;
    end

    // Unsigned results keep their upper bits clear.
    always_comb begin
        if (dec.zext && dec.is_byte)
            a_r9_zext_byte: assert (ld_data[DATA_W-1:8] == '0) else $error("byte zero-fill");
        if (dec.zext && dec.is_half)
            a_r9_zext_half: assert (ld_data[DATA_W-1:16] == '0) else $error("half zero-fill");
    end

endmodule

// File: rtl/mem_align_unit.sv
// Top of the load/store alignment path: word index, store strobe and data,
// load extraction and the misalignment flag. Purely combinational.
// Assumes a little-endian word memory with byte-wide strobes.
module mem_align_unit
    import mau_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] REGION_VALUE = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] REGION_CARE  = 32'hD000_0000
) (
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [2:0]                acc_size,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W-1:0]         rd_word,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic [DATA_W/8-1:0]       mem_wmask,
    output logic [DATA_W-1:0]         ld_data,
    output logic                      misaligned
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    size_dec_t        dec;
    logic             misalign_cond;
    logic             region_hit;
    logic             st_enable;
    logic [OFF_W-1:0] off;

    mau_access_check #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .REGION_VALUE(REGION_VALUE),
        .REGION_CARE (REGION_CARE)
    ) u_check (
        .addr         (acc_addr),
        .size_code    (acc_size),
        .dec          (dec),
        .misalign_cond(misalign_cond),
        .region_hit   (region_hit)
    );

    // Word index, lane offset, store gating and the exported flag.
    always_comb begin
        mem_word_addr = acc_addr[ADDR_W-1:OFF_W];
        off           = acc_addr[OFF_W-1:0];
        st_enable     = req_valid & req_write & region_hit & dec.legal & ~misalign_cond;
        misaligned    = req_valid & misalign_cond;
    end

    mau_store_pack #(
        .DATA_W(DATA_W)
    ) u_store (
        .dec    (dec),
        .off    (off),
        .enable (st_enable),
        .wr_data(wr_data),
        .wdata  (mem_wdata),
        .wmask  (mem_wmask)
    );

    mau_load_extract #(
        .DATA_W(DATA_W)
    ) u_load (
        .dec    (dec),
        .off    (off),
        .kill   (misalign_cond),
        .rd_word(rd_word),
        .ld_data(ld_data)
    );

    // Port-level guards on write protection.
    always_comb begin
        if (!(req_valid && req_write))
            a_r5_idle_no_write: assert (mem_wmask == '0) else $error("strobe without store");
        if (!region_hit)
            a_r6_window_no_write: assert (mem_wmask == '0) else $error("strobe outside window");
        if (misaligned)
            a_r7_misalign_no_write: assert (mem_wmask == '0) else $error("strobe on misaligned");
    end

endmodule

// File: tb/mem_align_unit_bench.sv
module mem_align_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_word = '0;
    logic [29:0] mem_word_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wmask;
    logic [31:0] ld_data;
    logic        misaligned;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mem_align_unit u_mem_align_unit (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .acc_addr     (acc_addr),
        .acc_size     (acc_size),
        .wr_data      (wr_data),
        .rd_word      (rd_word),
        .mem_word_addr(mem_word_addr),
        .mem_wdata    (mem_wdata),
        .mem_wmask    (mem_wmask),
        .ld_data      (ld_data),
        .misaligned   (misaligned)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit legal_code(input logic [2:0] s);
        return (s == 3'b000) || (s == 3'b001) || (s == 3'b010) || (s == 3'b100) || (s == 3'b101);
    endfunction

    function automatic bit bad_align(input logic [2:0] s, input logic [31:0] a);
        if (s == 3'b001 || s == 3'b101) return a[0];
        if (s == 3'b010) return a[1:0] != 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [3:0] model_mask(input logic v, input logic w,
                                              input logic [2:0] s, input logic [31:0] a);
        if (!(v && w) || !legal_code(s) || bad_align(s, a)) return 4'b0;
        if (a[31:30] != 2'b00 || a[28] != 1'b1) return 4'b0;
        case (s)
            3'b000, 3'b100: return 4'b0001 << a[1:0];
            3'b001, 3'b101: return 4'b0011 << a[1:0];
            default:        return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] model_wdata(input logic [2:0] s, input logic [31:0] d);
        case (s)
            3'b000, 3'b100: return {4{d[7:0]}};
            3'b001, 3'b101: return {2{d[15:0]}};
            default:        return d;
        endcase
    endfunction

    function automatic logic [31:0] model_load(input logic [2:0] s, input logic [31:0] a,
                                               input logic [31:0] r);
        logic [31:0] sh;
        if (!legal_code(s) || bad_align(s, a)) return 32'h0;
        sh = r >> (8 * a[1:0]);
        case (s)
            3'b000:  return $signed(sh[7:0]);
            3'b100:  return {24'h0, sh[7:0]};
            3'b001:  return $signed(sh[15:0]);
            3'b101:  return {16'h0, sh[15:0]};
            default: return r;
        endcase
    endfunction

    task automatic apply(input logic v, input logic w, input logic [2:0] s,
                         input logic [31:0] a, input logic [31:0] d, input logic [31:0] r);
        @(negedge clk);
        req_valid = v; req_write = w; acc_size = s; acc_addr = a; wr_data = d; rd_word = r;
        #1;
    endtask

    task automatic check_all(input string tag);
        check({tag, " R1 word addr"}, {2'b0, mem_word_addr}, {2'b0, acc_addr[31:2]});
        check({tag, " R3/R4/R5/R6 mask"}, {28'h0, mem_wmask},
              {28'h0, model_mask(req_valid, req_write, acc_size, acc_addr)});
        check({tag, " R7 misaligned"}, {31'h0, misaligned},
              {31'h0, req_valid & bad_align(acc_size, acc_addr)});
        check({tag, " R8-R12 load"}, ld_data, model_load(acc_size, acc_addr, rd_word));
        if (legal_code(acc_size))
            check({tag, " R2 wdata"}, mem_wdata, model_wdata(acc_size, wr_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset/idle state: no strobe, no flag (R5, R7).
        #1;
        check("R5 idle mask", {28'h0, mem_wmask}, 32'h0);
        check("R7 idle flag", {31'h0, misaligned}, 32'h0);

        // Lane picks from a known word, every offset (R8, R9, R10, R11).
        for (int o = 0; o < 4; o++) begin
            apply(1, 0, 3'b000, 32'h3000_0100 + o, 0, 32'hdeadbeef); check_all("R8 byte");
            apply(1, 0, 3'b100, 32'h3000_0100 + o, 0, 32'hdeadbeef); check_all("R9 ubyte");
        end
        apply(1, 0, 3'b000, 32'h3000_0100, 0, 32'hdeadbeef);
        check("R8 byte0 sign", ld_data, 32'hffffffef);
        apply(1, 0, 3'b001, 32'h3000_0102, 0, 32'hdeadbeef);
        check("R10 half2 sign", ld_data, 32'hffffdead);
        apply(1, 0, 3'b101, 32'h3000_0100, 0, 32'hdeadbeef);
        check("R9 uhalf0", ld_data, 32'h0000beef);
        apply(1, 0, 3'b100, 32'h3000_0103, 0, 32'hdeadbeef);
        check("R9 ubyte3", ld_data, 32'h000000de);
        apply(1, 0, 3'b010, 32'h3000_0100, 0, 32'hdeadbeef);
        check("R11 word", ld_data, 32'hdeadbeef);

        // Store strobes and replication per offset (R2, R3, R4).
        for (int o = 0; o < 4; o++) begin
            apply(1, 1, 3'b000, 32'h3000_0200 + o, 32'h12345678, 0);
            check("R3 byte strobe", {28'h0, mem_wmask}, {28'h0, 4'b0001 << o});
            check("R2 byte copy", mem_wdata, 32'h78787878);
        end
        apply(1, 1, 3'b001, 32'h3000_0202, 32'h12345678, 0);
        check("R4 half hi strobe", {28'h0, mem_wmask}, 32'hc);
        check("R2 half copy", mem_wdata, 32'h56785678);
        apply(1, 1, 3'b001, 32'h3000_0200, 32'h12345678, 0);
        check("R4 half lo strobe", {28'h0, mem_wmask}, 32'h3);
        apply(1, 1, 3'b010, 32'h3000_0200, 32'h12345678, 0);
        check("R4 word strobe", {28'h0, mem_wmask}, 32'hf);

        // Window: bit 29 ignored, bits 31:30 and 28 checked (R6).
        apply(1, 1, 3'b010, 32'h1000_0000, 32'h1, 0);
        check("R6 window 0x1", {28'h0, mem_wmask}, 32'hf);
        apply(1, 1, 3'b010, 32'h2000_0000, 32'h1, 0);
        check("R6 window 0x2", {28'h0, mem_wmask}, 32'h0);
        apply(1, 1, 3'b010, 32'h5000_0000, 32'h1, 0);
        check("R6 window 0x5", {28'h0, mem_wmask}, 32'h0);

        // Misaligned and illegal codes (R7, R12).
        apply(1, 1, 3'b001, 32'h3000_0101, 32'h1, 32'hdeadbeef);
        check("R7 odd half flag", {31'h0, misaligned}, 32'h1);
        check("R7 odd half mask", {28'h0, mem_wmask}, 32'h0);
        check("R12 odd half load", ld_data, 32'h0);
        apply(1, 0, 3'b010, 32'h3000_0102, 0, 32'hdeadbeef);
        check("R7 word off2 flag", {31'h0, misaligned}, 32'h1);
        check("R12 word off2 load", ld_data, 32'h0);
        apply(1, 1, 3'b011, 32'h3000_0100, 32'h1, 32'hdeadbeef);
        check("R12 illegal mask", {28'h0, mem_wmask}, 32'h0);
        check("R12 illegal load", ld_data, 32'h0);
        check("R12 illegal flag", {31'h0, misaligned}, 32'h0);
        apply(0, 1, 3'b010, 32'h3000_0100, 32'h1, 0);
        check("R5 not valid", {28'h0, mem_wmask}, 32'h0);

        // Constrained random mix.
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a;
            logic [2:0]  s;
            a = $urandom;
            if ($urandom_range(3) != 0) a[31:28] = ($urandom_range(1) != 0) ? 4'h1 : 4'h3;
            s = ($urandom_range(7) == 0) ? 3'($urandom) :
                ((($urandom_range(4)) == 0) ? 3'b000 :
                 (($urandom_range(3)) == 0) ? 3'b001 :
                 (($urandom_range(2)) == 0) ? 3'b010 :
                 (($urandom_range(1)) == 0) ? 3'b100 : 3'b101);
            apply($urandom_range(9) != 0, $urandom_range(1) != 0, s, a, $urandom, $urandom);
            check_all("rand");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule